// File: doc/BRIEF.md
# Two-Stage 8:1 Serializer Tree

This block turns a parallel word of eight lanes into one serial bit stream. The stream runs at eight times the word rate. The block is clocked only by the fast bit clock. Inside it, a divide-by-2 stage feeds a divide-by-4 stage, and together they give every slower timing the block uses. The block also exports that word-rate timing as a pair of complementary clock outputs, so that the logic upstream can present a new word once per word period.

A word is taken into a capture register on the bit-clock edge where the divided word clock falls. The even lanes then pass through one 4:1 selection stage and the odd lanes through a second one. Each of these stages is registered at half the bit rate. A full-rate 2:1 interleaver alternates between the two stages and drives a final output flop. Lane 0 of a word leaves first and lane 7 leaves last. The next word follows with no gap.

Top module: `ser8_tree`

## Requirements
- R1: A synchronous active-high `rst` clears the divider chain, the capture register, both group stages and the output flop. On the clock edge after `rst` is sampled high, `ser_out` is 0, `wclk_p` is 0 and `wclk_n` is 1. This also holds when reset arrives in the middle of a word.
- R2: Let n be the number of bit-clock edges since reset was released. After edge n, `wclk_p` is 1 when (n mod 8) is 4 or more, and 0 otherwise. It is the bit clock divided by eight with a 50 % duty cycle.
- R3: `wclk_n` is always the logical inverse of `wclk_p` while out of reset.
- R4: `word_in` is captured only on the edges where `wclk_p` falls, that is edges n = 8, 16, 24 and so on. Values on `word_in` at any other edge have no effect on the serial stream.
- R5: Within a word, the bits leave in lane order: bit 0 of the captured word first, then bits 1 to 7 in ascending order, one per bit clock.
- R6: The latency is fixed. For a word captured on edge 8k, bit i appears on `ser_out` after edge 8k+2+i. Consecutive words follow each other without idle bits.
- R7: Between reset release and the first serial bit (after edges 1 to 9), `ser_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | LANES | Parallel word, bit i is lane i |
| ser_out | output | 1 | Serial output, registered |
| wclk_p | output | 1 | Word-rate clock (bit clock / 8) |
| wclk_n | output | 1 | Complement of `wclk_p` |

## Verification
The hardest condition to create from the ports is one where capturing on the wrong edge would still look correct. That happens if `word_in` holds the same value for the whole word period. To rule it out, the bench drives a new pseudo-random value on `word_in` every bit clock. It places the intended word only in the single cycle before each capture edge, so any off-by-one in the capture or the lane selection shows up as corrupted bits. A reset is also asserted five cycles into a word. The bench checks that the stream restarts cleanly, with the same latency, after that reset.

// File: rtl/ser8_pkg.sv
package ser8_pkg;

   // Pipeline depth from the capture register to ser_out: one group-stage
   // register followed by the output flop.
   localparam int unsigned SER_LAT = 2;

   // Which half feeds the interleaver in a given bit slot.
   typedef enum logic {
      PICK_ODD  = 1'b0,
      PICK_EVEN = 1'b1
   } half_sel_e;

   // Group selection implementation variants.
   typedef enum int {
      GSEL_INDEX = 0,
      GSEL_ANDOR = 1
   } gsel_style_e;

endpackage

// File: rtl/ser8_clkdiv.sv
module ser8_clkdiv
   import ser8_pkg::*;
#(
   parameter int LANES    = 8,
   parameter bit COMP_REG = 1'b1,
   localparam int PH_W    = $clog2(LANES),
   localparam int SLOW_W  = PH_W - 1
) (
   input  logic              clk,
   input  logic              rst,
   output logic              half_q,
   output logic [SLOW_W-1:0] slow_q,
   output logic              word_ld,
   output logic              grp_ld,
   output half_sel_e         pick,
   output logic              wclk_p,
   output logic              wclk_n
);

   logic [PH_W-1:0] phase;
   logic            wp_q;
   logic            wp_d;

   // First stage: divide by two.
   always_ff @(posedge clk) begin
      if (rst) half_q <= 1'b0;
      else     half_q <= ~half_q;
   end

   // Second stage: divide the half-rate clock by the group size.
   always_ff @(posedge clk) begin
      if (rst)         slow_q <= '0;
      else if (half_q) slow_q <= slow_q + 1'b1;
   end

   assign phase   = {slow_q, half_q};
   assign word_ld = (phase == PH_W'(LANES - 1));
   assign grp_ld  = ~half_q;
   assign pick    = half_q ? PICK_EVEN : PICK_ODD;

   // Word clock: rises halfway through the word period, falls on the last slot.
   always_comb begin
      wp_d = wp_q;
      if (phase == PH_W'(LANES / 2 - 1)) wp_d = 1'b1;
      if (phase == PH_W'(LANES - 1))     wp_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) wp_q <= 1'b0;
      else     wp_q <= wp_d;
   end

   assign wclk_p = wp_q;

   generate
      if (COMP_REG) begin : g_comp_flop
         logic wn_q;
         always_ff @(posedge clk) begin
            if (rst) wn_q <= 1'b1;
            else     wn_q <= ~wp_d;
         end
         assign wclk_n = wn_q;
      end else begin : g_comp_inv
         assign wclk_n = ~wp_q;
      end
   endgenerate

endmodule

// File: rtl/ser8_grpsel.sv
module ser8_grpsel
   import ser8_pkg::*;
#(
   parameter int GRP   = 4,
   parameter int STYLE = GSEL_INDEX,
   localparam int SEL_W = (GRP > 1) ? $clog2(GRP) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld,
   input  logic [SEL_W-1:0] sel,
   input  logic [GRP-1:0]   lanes,
   output logic             bit_q
);

   logic pick_bit;

   generate
      if (STYLE == GSEL_ANDOR) begin : g_andor
         always_comb begin
            pick_bit = 1'b0;
            for (int i = 0; i < GRP; i++) begin
               pick_bit = pick_bit | (lanes[i] & (sel == SEL_W'(i)));
            end
         end
      end else begin : g_index
         assign pick_bit = lanes[sel];
      end
   endgenerate

   // Half-rate register: updated once per pair of bit slots.
   always_ff @(posedge clk) begin
      if (rst)     bit_q <= 1'b0;
      else if (ld) bit_q <= pick_bit;
   end

endmodule

// File: rtl/ser8_ilv.sv
module ser8_ilv
   import ser8_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  half_sel_e pick,
   input  logic      even_bit,
   input  logic      odd_bit,
   output logic      ser_q
);

   logic mux_bit;

   assign mux_bit = (pick == PICK_EVEN) ? even_bit : odd_bit;

   // Full-rate output flop.
   always_ff @(posedge clk) begin
      if (rst) ser_q <= 1'b0;
      else     ser_q <= mux_bit;
   end

endmodule

// File: rtl/ser8_tree.sv
module ser8_tree
   import ser8_pkg::*;
#(
   parameter int LANES     = 8,
   parameter int GSEL      = GSEL_INDEX,
   parameter bit COMP_REG  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LANES-1:0] word_in,
   output logic             ser_out,
   output logic             wclk_p,
   output logic             wclk_n
);

   localparam int HALVES = 2;
   localparam int GRP    = LANES / HALVES;
   localparam int PH_W   = $clog2(LANES);
   localparam int SLOW_W = PH_W - 1;

   generate
      if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("ser8_tree: LANES must be a power of two of at least 4");
      end
      if (LANES > 64) begin : g_big_lanes
         $error("ser8_tree: LANES above 64 not supported");
      end
      if (GSEL != GSEL_INDEX && GSEL != GSEL_ANDOR) begin : g_bad_style
         $error("ser8_tree: unknown GSEL style");
      end
   endgenerate

   logic                         half_q;
   logic [SLOW_W-1:0]            slow_q;
   logic                         word_ld;
   logic                         grp_ld;
   half_sel_e                    pick;
   logic [LANES-1:0]             cap_q;
   logic [HALVES-1:0][GRP-1:0]   half_lanes;
   logic [HALVES-1:0]            grp_bit;

   ser8_clkdiv #(
      .LANES   (LANES),
      .COMP_REG(COMP_REG)
   ) u_div (
      .clk    (clk),
      .rst    (rst),
      .half_q (half_q),
      .slow_q (slow_q),
      .word_ld(word_ld),
      .grp_ld (grp_ld),
      .pick   (pick),
      .wclk_p (wclk_p),
      .wclk_n (wclk_n)
   );

   // Word capture on the falling edge of the divided word clock.
   always_ff @(posedge clk) begin
      if (rst)          cap_q <= '0;
      else if (word_ld) cap_q <= word_in;
   end

   // Split lanes: half 0 carries even lanes, half 1 carries odd lanes.
   generate
      for (genvar h = 0; h < HALVES; h++) begin : g_half
         for (genvar k = 0; k < GRP; k++) begin : g_lane
            assign half_lanes[h][k] = cap_q[HALVES * k + h];
         end
         ser8_grpsel #(
            .GRP  (GRP),
            .STYLE(GSEL)
         ) u_grp (
            .clk  (clk),
            .rst  (rst),
            .ld   (grp_ld),
            .sel  (slow_q),
            .lanes(half_lanes[h]),
            .bit_q(grp_bit[h])
         );
      end
   endgenerate

   ser8_ilv u_ilv (
      .clk     (clk),
      .rst     (rst),
      .pick    (pick),
      .even_bit(grp_bit[0]),
      .odd_bit (grp_bit[1]),
      .ser_q   (ser_out)
   );

   // half_q is consumed by the divider outputs; keep it referenced here.
   logic unused_ok;
   assign unused_ok = half_q;

endmodule

// File: rtl/ser8_tree_chk.sv
module ser8_tree_chk #(
   parameter int LANES = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             wclk_p,
   input logic             wclk_n,
   input logic             ser_out,
   input logic [LANES-1:0] cap_q
);

   localparam int PH_W = $clog2(LANES);
   localparam int WARM = LANES + 2;

   logic [PH_W-1:0]  ph;
   logic [7:0]       warm;
   logic [LANES-1:0] cap_d1;
   logic [LANES-1:0] cap_d2;
   logic [PH_W-1:0]  idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph   <= '0;
         warm <= '0;
      end else begin
         ph   <= ph + 1'b1;
         warm <= (warm == 8'(WARM)) ? warm : warm + 8'd1;
      end
      cap_d1 <= cap_q;
      cap_d2 <= cap_d1;
   end

   assign idx = ph - PH_W'(2);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (!ser_out && !wclk_p && wclk_n));

   // R2
   word_clock_chk: assert property (@(posedge clk) disable iff (rst)
      wclk_p == ph[PH_W-1]);

   // R3
   comp_clock_chk: assert property (@(posedge clk) disable iff (rst)
      wclk_n != wclk_p);

   // R4
   capture_edge_chk: assert property (@(posedge clk) disable iff (rst)
      !$fell(wclk_p) |-> $stable(cap_q));

   // R5 R6
   lane_order_chk: assert property (@(posedge clk) disable iff (rst)
      (warm >= 8'(WARM)) |-> (ser_out == cap_d2[idx]));

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (warm < 8'(WARM)) |-> !ser_out);

endmodule

bind ser8_tree ser8_tree_chk #(.LANES(LANES)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .wclk_p (wclk_p),
   .wclk_n (wclk_n),
   .ser_out(ser_out),
   .cap_q  (cap_q)
);

// File: tb/sim_ser8_tree.sv
module sim_ser8_tree;

   localparam int LANES = 8;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [LANES-1:0] word_in = '0;
   logic             ser_out;
   logic             wclk_p;
   logic             wclk_n;

   always #5 clk = ~clk;

   ser8_tree #(.LANES(LANES)) u0 (
      .clk    (clk),
      .rst    (rst),
      .word_in(word_in),
      .ser_out(ser_out),
      .wclk_p (wclk_p),
      .wclk_n (wclk_n)
   );

   int               checks = 0;
   int               errors = 0;
   bit               done   = 1'b0;
   int               n      = 0;
   int               wnum   = 0;
   bit               bq[$];
   logic [LANES-1:0] wq[$];
   logic [LANES-1:0] got = '0;
   logic [15:0]      lf  = 16'hACE1;

   task automatic chk(input string tag, input logic [31:0] act,
                      input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h (edge %0d)", tag, what, act, exp, n);
      end
   endtask

   function automatic logic [LANES-1:0] word_of(input int w);
      case (w)
         0: return 8'h00;
         1: return 8'hFF;
         2: return 8'h55;
         3: return 8'hAA;
         default: begin
            if (w < 12) return 8'(1 << (w - 4));
            return 8'((w * 37 + 11) ^ ((w >> 2) * 91));
         end
      endcase
   endfunction

   // One bit clock: drive word_in, advance, then compare against the model.
   task automatic tick();
      logic [LANES-1:0] w;
      int               lane;
      if (((n + 1) % LANES) == 0) begin
         w = word_of(wnum);
         wnum++;
         word_in = w;
         wq.push_back(w);
         for (int i = 0; i < LANES; i++) bq.push_back(w[i]);
      end else begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         word_in = lf[7:0];
      end
      @(posedge clk);
      n++;
      @(negedge clk);
      chk("R2", 32'(wclk_p), 32'((n % LANES) >= LANES / 2), "wclk_p");
      chk("R3", 32'(wclk_n), 32'(!((n % LANES) >= LANES / 2)), "wclk_n");
      if (n < LANES + 2) begin
         chk("R7", 32'(ser_out), 32'd0, "ser_out before first bit");
      end else begin
         lane = (n - LANES - 2) % LANES;
         chk((lane == 0) ? "R6" : "R5", 32'(ser_out), 32'(bq.pop_front()), "ser_out bit");
         got[lane] = ser_out;
         if (lane == LANES - 1) chk("R4", 32'(got), 32'(wq.pop_front()), "assembled word");
      end
   endtask

   task automatic check_reset_state();
      chk("R1", 32'(ser_out), 32'd0, "ser_out in reset");
      chk("R1", 32'(wclk_p), 32'd0, "wclk_p in reset");
      chk("R1", 32'(wclk_n), 32'd1, "wclk_n in reset");
   endtask

   initial begin
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_reset_state();
      rst = 1'b0;
      n   = 0;
      repeat (LANES * 30) tick();
      // reset in the middle of a word
      repeat (5) tick();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check_reset_state();
      @(posedge clk);
      @(negedge clk);
      check_reset_state();
      rst = 1'b0;
      n   = 0;
      bq.delete();
      wq.delete();
      repeat (LANES * 12) tick();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule